// File: doc/BRIEF.md
# Correlator Channel Dump Status Snapshot

This block keeps the per-channel status that a multi-channel correlator produces each time a channel dumps its accumulated results, and presents that status to a host through two read-only snapshot words on a simple address/data bus. For each channel it holds a live "data ready" flag, which also acts as overwrite protection. It also holds a sticky "dump lost" flag, a sticky overflow flag and an early/late indicator for the dithering arm. A single "statistics ready" flag is kept for the whole block.

The host never reads the live flags directly. Both snapshot words are loaded together on a rising edge of either interrupt line, or when the host writes any data to the capture address. After a channel's data has been consumed, the host reads that channel's prompt-quadrature address. When the read strobe falls, the channel's protection is released, unless that channel dumped again after the most recent snapshot. In that case protection stays on, so the newer dump is reported at the next snapshot rather than lost silently.

Top module: `acc_status_latch`

## Requirements
- R1: A low `rst_n` or a high `sw_reset` at a clock edge clears every live flag and both snapshot words, so that both read as 0000h afterwards.
- R2: While `bus_rd` is high with `bus_addr` = 82h, `bus_rdata` shows snapshot A in the same cycle. Bit c (c = 0..5) is the data-ready flag of channel c, bit 8+c is its early flag (1 = early, 0 = late), bit 15 is the statistics-ready flag, and bits 6, 7 and 14 are 0. Any other read address, or no read, gives 0000h.
- R3: With `bus_rd` high and `bus_addr` = 83h, `bus_rdata` shows snapshot B. Bit c is the dump-lost flag of channel c, bit 8+c is its overflow flag, and bits 6, 7, 14 and 15 are 0.
- R4: Both snapshots load the live flags as they stood before a clock edge when, at that edge, `irq_out` or `irq_in` is sampled high after being sampled low at the previous edge, or `bus_wr` is high with `bus_addr` = 80h. Otherwise they hold their value.
- R5: A dump on a channel whose data-ready flag is clear sets that flag, which turns protection on. It loads the early flag from `ch_dump_early`, and sets the overflow flag if `ch_dump_ovfl` is high.
- R6: A dump on a protected channel sets its sticky dump-lost flag and leaves the early and overflow flags unchanged.
- R7: A read of address 90h+c clears channel c's data-ready flag at its trailing edge, unless channel c dumped after the last snapshot or in that same cycle. In that case the flag stays set and appears in the next snapshot.
- R8: A write to address 88h+c clears channel c's data-ready, dump-lost and overflow flags. If a dump arrives in the same cycle, the dump is applied after the clear.
- R9: While `ch_clk_en[c]` is low, channel c's data-ready, dump-lost and overflow flags are held clear, its early flag keeps its value, and its dumps are ignored.
- R10: A `stat_new` pulse sets the statistics-ready flag. The flag clears at the trailing edge of a read of address 98h only if snapshot A bit 15 is 1, and it clears on a write to 8Fh. A set in the same cycle wins over a clear.
- R11: Read-triggered clears take effect at the clock edge where `bus_rd` is first sampled low, not while the strobe is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware master reset, active low |
| sw_reset | input | 1 | Synchronous software master reset |
| irq_out | input | 1 | Outgoing interrupt line; a rising edge loads the snapshots |
| irq_in | input | 1 | Incoming interrupt line; a rising edge loads the snapshots |
| bus_addr | input | 8 | Host address |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_rd | input | 1 | Host read strobe, high for the length of a read |
| bus_rdata | output | 16 | Read data, snapshot A or B, otherwise zero |
| ch_clk_en | input | 6 | Per-channel clock enable; low holds the channel cleared |
| ch_dump | input | 6 | Per-channel dump pulse |
| ch_dump_early | input | 6 | Early (1) or late (0) code of the dump |
| ch_dump_ovfl | input | 6 | Overflow indication of the dump |
| stat_new | input | 1 | New statistics pulse |

## Verification
Every flag update and every snapshot load happens at the clock edge that samples its stimulus. Snapshot contents reach `bus_rdata` in the same cycle as the read strobe. A read-triggered clear lands at the first edge that samples `bus_rd` low. The bench drives inputs 1 ns after a rising edge. It advances a behavioural model at each rising edge and compares the read bus at each falling edge, so every result is checked in the cycle it becomes due. Directed sequences then read the snapshot words only after an explicit capture, so each expected word reflects exactly the edges that preceded it.

// File: rtl/acsl_pkg.sv
package acsl_pkg;

   localparam int unsigned ADDR_CAPTURE_DEF = 'h80;
   localparam int unsigned ADDR_SNAP_A_DEF  = 'h82;
   localparam int unsigned ADDR_SNAP_B_DEF  = 'h83;
   localparam int unsigned ADDR_CH_CLR_DEF  = 'h88;
   localparam int unsigned ADDR_ALL_CLR_DEF = 'h8F;
   localparam int unsigned ADDR_QPROMPT_DEF = 'h90;
   localparam int unsigned ADDR_STATMAG_DEF = 'h98;

   typedef struct packed {
      logic early;
      logic ovfl;
      logic missed;
      logic ready;
   } acsl_ch_flags_t;

endpackage

// File: rtl/acsl_bus_decode.sv
module acsl_bus_decode #(
   parameter int NUM_CH       = 6,
   parameter int ADDR_W       = 8,
   parameter int ADDR_CAPTURE = 'h80,
   parameter int ADDR_CH_CLR  = 'h88,
   parameter int ADDR_ALL_CLR = 'h8F,
   parameter int ADDR_QPROMPT = 'h90,
   parameter int ADDR_STATMAG = 'h98
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_reset,
   input  logic              irq_out,
   input  logic              irq_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic              snap_evt,
   output logic              all_clr,
   output logic              mag_rd_done,
   output logic [NUM_CH-1:0] ch_clr,
   output logic [NUM_CH-1:0] qp_rd_done
);

   logic              irq_out_q;
   logic              irq_in_q;
   logic              rd_q;
   logic [ADDR_W-1:0] rd_addr_q;
   logic              rd_trail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out_q <= 1'b0;
         irq_in_q  <= 1'b0;
         rd_q      <= 1'b0;
         rd_addr_q <= '0;
      end else if (sw_reset) begin
         irq_out_q <= 1'b0;
         irq_in_q  <= 1'b0;
         rd_q      <= 1'b0;
         rd_addr_q <= '0;
      end else begin
         irq_out_q <= irq_out;
         irq_in_q  <= irq_in;
         rd_q      <= bus_rd;
         if (bus_rd) rd_addr_q <= bus_addr;
      end
   end

   assign rd_trail    = rd_q && !bus_rd;
   assign snap_evt    = (irq_out && !irq_out_q) || (irq_in && !irq_in_q) ||
                        (bus_wr && bus_addr == ADDR_W'(ADDR_CAPTURE));
   assign all_clr     = bus_wr && bus_addr == ADDR_W'(ADDR_ALL_CLR);
   assign mag_rd_done = rd_trail && rd_addr_q == ADDR_W'(ADDR_STATMAG);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_dec
      assign ch_clr[c]     = bus_wr && bus_addr == ADDR_W'(ADDR_CH_CLR + c);
      assign qp_rd_done[c] = rd_trail && rd_addr_q == ADDR_W'(ADDR_QPROMPT + c);
   end

   // R11: no read-triggered clear may fire while the strobe is still high
   assert_no_clear_while_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_rd) && bus_rd |-> (qp_rd_done == '0) && !mag_rd_done);

endmodule

// File: rtl/acsl_channel.sv
module acsl_channel
   import acsl_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sw_reset,
   input  logic           clk_en,
   input  logic           dump,
   input  logic           dump_early,
   input  logic           dump_ovfl,
   input  logic           acc_clr,
   input  logic           qp_rd_done,
   input  logic           snap_evt,
   output acsl_ch_flags_t flags
);

   logic ready_q, missed_q, ovfl_q, early_q, fresh_q;
   logic ready_nxt, missed_nxt, ovfl_nxt, early_nxt, fresh_nxt;
   logic rd_release;

   always_comb begin
      rd_release = qp_rd_done && !fresh_q && !dump;
      ready_nxt  = (acc_clr || rd_release) ? 1'b0 : ready_q;
      missed_nxt = acc_clr ? 1'b0 : missed_q;
      ovfl_nxt   = acc_clr ? 1'b0 : ovfl_q;
      early_nxt  = early_q;
      if (dump) begin
         if (ready_nxt) begin
            missed_nxt = 1'b1;
         end else begin
            ready_nxt = 1'b1;
            early_nxt = dump_early;
            ovfl_nxt  = ovfl_nxt | dump_ovfl;
         end
      end
      fresh_nxt = dump | (fresh_q & ~snap_evt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q  <= 1'b0;
         missed_q <= 1'b0;
         ovfl_q   <= 1'b0;
         early_q  <= 1'b0;
         fresh_q  <= 1'b0;
      end else if (sw_reset) begin
         ready_q  <= 1'b0;
         missed_q <= 1'b0;
         ovfl_q   <= 1'b0;
         early_q  <= 1'b0;
         fresh_q  <= 1'b0;
      end else if (!clk_en) begin
         ready_q  <= 1'b0;
         missed_q <= 1'b0;
         ovfl_q   <= 1'b0;
         fresh_q  <= 1'b0;
      end else begin
         ready_q  <= ready_nxt;
         missed_q <= missed_nxt;
         ovfl_q   <= ovfl_nxt;
         early_q  <= early_nxt;
         fresh_q  <= fresh_nxt;
      end
   end

   assign flags = '{early: early_q, ovfl: ovfl_q, missed: missed_q, ready: ready_q};

   // R6: the lost-dump flag only rises on a dump that met protection
   assert_missed_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(missed_q) |-> $past(ready_q && dump));

   // R6: the lost-dump flag is sticky
   assert_missed_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      missed_q && clk_en && !acc_clr && !sw_reset |=> missed_q);

   // R5: the early flag is frozen while protection is on
   assert_early_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q && clk_en && !acc_clr && !sw_reset |=> $stable(early_q));

   // R7: a dump since the last snapshot keeps protection through a prompt read
   assert_read_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q && fresh_q && clk_en && !acc_clr && !sw_reset |=> ready_q);

   // R9: a disabled channel holds its flags clear
   assert_clk_en_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> !ready_q && !missed_q && !ovfl_q);

endmodule

// File: rtl/acsl_stat_flag.sv
module acsl_stat_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_reset,
   input  logic stat_new,
   input  logic mag_rd_done,
   input  logic all_clr,
   input  logic snap_stat,
   output logic stat_q
);

   logic clr;

   assign clr = (mag_rd_done && snap_stat) || all_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q <= 1'b0;
      else if (sw_reset) stat_q <= 1'b0;
      else               stat_q <= (stat_q && !clr) || stat_new;
   end

   // R10: a new-statistics pulse always leaves the flag set
   assert_stat_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stat_new && !sw_reset |=> stat_q);

   // R10: a magnitude read does not clear a flag the snapshot did not show
   assert_stat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q && !snap_stat && !all_clr && !sw_reset |=> stat_q);

endmodule

// File: rtl/acsl_snapshot.sv
module acsl_snapshot #(
   parameter int NUM_CH      = 6,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 8,
   parameter int ADDR_SNAP_A = 'h82,
   parameter int ADDR_SNAP_B = 'h83
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_reset,
   input  logic              snap_evt,
   input  logic [NUM_CH-1:0] ready_vec,
   input  logic [NUM_CH-1:0] early_vec,
   input  logic [NUM_CH-1:0] missed_vec,
   input  logic [NUM_CH-1:0] ovfl_vec,
   input  logic              stat_live,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              snap_stat
);

   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] live_a, live_b;
   logic [DATA_W-1:0] snap_a, snap_b;

   always_comb begin
      live_a                = '0;
      live_a[NUM_CH-1:0]    = ready_vec;
      live_a[HALF +: NUM_CH] = early_vec;
      live_a[DATA_W-1]      = stat_live;
      live_b                = '0;
      live_b[NUM_CH-1:0]    = missed_vec;
      live_b[HALF +: NUM_CH] = ovfl_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_a <= '0;
         snap_b <= '0;
      end else if (sw_reset) begin
         snap_a <= '0;
         snap_b <= '0;
      end else if (snap_evt) begin
         snap_a <= live_a;
         snap_b <= live_b;
      end
   end

   assign snap_stat = snap_a[DATA_W-1];

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && bus_addr == ADDR_W'(ADDR_SNAP_A))      bus_rdata = snap_a;
      else if (bus_rd && bus_addr == ADDR_W'(ADDR_SNAP_B)) bus_rdata = snap_b;
   end

   // R4: without a capture event both words hold
   assert_snap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_evt && !sw_reset |=> $stable(snap_a) && $stable(snap_b));

   // R1: a software reset empties both words
   assert_sw_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sw_reset |=> snap_a == '0 && snap_b == '0);

endmodule

// File: rtl/acc_status_latch.sv
module acc_status_latch
   import acsl_pkg::*;
#(
   parameter int NUM_CH       = 6,
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 8,
   parameter int ADDR_CAPTURE = ADDR_CAPTURE_DEF,
   parameter int ADDR_SNAP_A  = ADDR_SNAP_A_DEF,
   parameter int ADDR_SNAP_B  = ADDR_SNAP_B_DEF,
   parameter int ADDR_CH_CLR  = ADDR_CH_CLR_DEF,
   parameter int ADDR_ALL_CLR = ADDR_ALL_CLR_DEF,
   parameter int ADDR_QPROMPT = ADDR_QPROMPT_DEF,
   parameter int ADDR_STATMAG = ADDR_STATMAG_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_reset,
   input  logic              irq_out,
   input  logic              irq_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] ch_clk_en,
   input  logic [NUM_CH-1:0] ch_dump,
   input  logic [NUM_CH-1:0] ch_dump_early,
   input  logic [NUM_CH-1:0] ch_dump_ovfl,
   input  logic              stat_new
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("acc_status_latch: DATA_W must be even");
   end
   if (NUM_CH < 1 || NUM_CH > DATA_W / 2 - 1) begin : g_bad_count
      $error("acc_status_latch: NUM_CH does not fit the snapshot layout");
   end
   if (ADDR_CH_CLR + NUM_CH > ADDR_SPAN || ADDR_QPROMPT + NUM_CH > ADDR_SPAN) begin : g_bad_map
      $error("acc_status_latch: channel address ranges exceed the address space");
   end

   logic              snap_evt, all_clr, mag_rd_done, snap_stat, stat_q;
   logic [NUM_CH-1:0] ch_clr, qp_rd_done;
   logic [NUM_CH-1:0] ready_vec, early_vec, missed_vec, ovfl_vec;
   acsl_ch_flags_t    ch_flags [NUM_CH];

   acsl_bus_decode #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .ADDR_CAPTURE(ADDR_CAPTURE),
      .ADDR_CH_CLR(ADDR_CH_CLR), .ADDR_ALL_CLR(ADDR_ALL_CLR),
      .ADDR_QPROMPT(ADDR_QPROMPT), .ADDR_STATMAG(ADDR_STATMAG)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
      .irq_out(irq_out), .irq_in(irq_in),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .snap_evt(snap_evt), .all_clr(all_clr), .mag_rd_done(mag_rd_done),
      .ch_clr(ch_clr), .qp_rd_done(qp_rd_done)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      acsl_channel u_ch (
         .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
         .clk_en(ch_clk_en[c]), .dump(ch_dump[c]),
         .dump_early(ch_dump_early[c]), .dump_ovfl(ch_dump_ovfl[c]),
         .acc_clr(ch_clr[c]), .qp_rd_done(qp_rd_done[c]),
         .snap_evt(snap_evt), .flags(ch_flags[c])
      );
      assign ready_vec[c]  = ch_flags[c].ready;
      assign early_vec[c]  = ch_flags[c].early;
      assign missed_vec[c] = ch_flags[c].missed;
      assign ovfl_vec[c]   = ch_flags[c].ovfl;
   end

   acsl_stat_flag u_stat (
      .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
      .stat_new(stat_new), .mag_rd_done(mag_rd_done), .all_clr(all_clr),
      .snap_stat(snap_stat), .stat_q(stat_q)
   );

   acsl_snapshot #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .ADDR_SNAP_A(ADDR_SNAP_A), .ADDR_SNAP_B(ADDR_SNAP_B)
   ) u_snap (
      .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .snap_evt(snap_evt),
      .ready_vec(ready_vec), .early_vec(early_vec),
      .missed_vec(missed_vec), .ovfl_vec(ovfl_vec), .stat_live(stat_q),
      .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_rdata(bus_rdata), .snap_stat(snap_stat)
   );

endmodule

// File: tb/acc_status_latch_test.sv
`timescale 1ns/100ps
module acc_status_latch_test;

   localparam int NC = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_reset = 1'b0;
   logic          irq_out = 1'b0;
   logic          irq_in = 1'b0;
   logic [7:0]    bus_addr = 8'h00;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [15:0]   bus_rdata;
   logic [NC-1:0] ch_clk_en = '1;
   logic [NC-1:0] ch_dump = '0;
   logic [NC-1:0] ch_dump_early = '0;
   logic [NC-1:0] ch_dump_ovfl = '0;
   logic          stat_new = 1'b0;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   acc_status_latch uut (
      .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
      .irq_out(irq_out), .irq_in(irq_in),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ch_clk_en(ch_clk_en), .ch_dump(ch_dump),
      .ch_dump_early(ch_dump_early), .ch_dump_ovfl(ch_dump_ovfl),
      .stat_new(stat_new)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Behavioural reference: flags per channel, captured words, strobe history
   logic [NC-1:0] m_rdy = '0, m_mis = '0, m_ovf = '0, m_ear = '0, m_frs = '0;
   logic          m_stat = 1'b0, m_iqo = 1'b0, m_iqi = 1'b0, m_rdq = 1'b0;
   logic [7:0]    m_rda = 8'h00;
   logic [15:0]   mA = '0, mB = '0;
   logic          t_snap, t_stclr;

   always @(posedge clk) begin
      if (!rst_n || sw_reset) begin
         m_rdy = '0; m_mis = '0; m_ovf = '0; m_ear = '0; m_frs = '0;
         m_stat = 1'b0; m_iqo = 1'b0; m_iqi = 1'b0; m_rdq = 1'b0; m_rda = 8'h00;
         mA = '0; mB = '0;
      end else begin
         t_snap = (irq_out && !m_iqo) || (irq_in && !m_iqi) || (bus_wr && bus_addr == 8'h80);
         t_stclr = (m_rdq && !bus_rd && m_rda == 8'h98 && mA[15]) || (bus_wr && bus_addr == 8'h8F);
         if (t_snap) begin
            mA = '0; mB = '0;
            for (int c = 0; c < NC; c++) begin
               mA[c] = m_rdy[c]; mA[8+c] = m_ear[c];
               mB[c] = m_mis[c]; mB[8+c] = m_ovf[c];
            end
            mA[15] = m_stat;
         end
         m_stat = (m_stat && !t_stclr) || stat_new;
         for (int c = 0; c < NC; c++) begin
            if (!ch_clk_en[c]) begin
               m_rdy[c] = 1'b0; m_mis[c] = 1'b0; m_ovf[c] = 1'b0; m_frs[c] = 1'b0;
            end else begin
               if (bus_wr && bus_addr == 8'(8'h88 + c)) begin
                  m_rdy[c] = 1'b0; m_mis[c] = 1'b0; m_ovf[c] = 1'b0;
               end else if (m_rdq && !bus_rd && m_rda == 8'(8'h90 + c) && !m_frs[c] && !ch_dump[c]) begin
                  m_rdy[c] = 1'b0;
               end
               if (ch_dump[c]) begin
                  if (m_rdy[c]) m_mis[c] = 1'b1;
                  else begin
                     m_rdy[c] = 1'b1;
                     m_ear[c] = ch_dump_early[c];
                     if (ch_dump_ovfl[c]) m_ovf[c] = 1'b1;
                  end
               end
               m_frs[c] = ch_dump[c] || (m_frs[c] && !t_snap);
            end
         end
         m_iqo = irq_out; m_iqi = irq_in; m_rdq = bus_rd;
         if (bus_rd) m_rda = bus_addr;
      end
   end

   // Every clock: compare the read bus against the reference (R2, R3)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (bus_rd && bus_addr == 8'h82)      chk("R2 model read", bus_rdata, mA);
         else if (bus_rd && bus_addr == 8'h83) chk("R3 model read", bus_rdata, mB);
         else                                  chk("R2 idle bus zero", bus_rdata, 16'h0000);
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [7:0] a);
      step(); bus_wr = 1'b1; bus_addr = a;
      step(); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] v);
      step(); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); v = bus_rdata;
      step(); bus_rd = 1'b0;
   endtask

   task automatic dump1(input int c, input logic e, input logic o);
      step(); ch_dump[c] = 1'b1; ch_dump_early[c] = e; ch_dump_ovfl[c] = o;
      step(); ch_dump = '0; ch_dump_early = '0; ch_dump_ovfl = '0;
   endtask

   task automatic snap_check(input string req, input logic [15:0] ea, input logic [15:0] eb);
      logic [15:0] v;
      wr(8'h80);
      rd(8'h82, v); chk({req, " word A"}, v, ea);
      rd(8'h83, v); chk({req, " word B"}, v, eb);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1: reset state
      rd(8'h82, v); chk("R1 reset word A", v, 16'h0000);
      rd(8'h83, v); chk("R1 reset word B", v, 16'h0000);

      // R5: unprotected dumps; R2/R3 layout; R4 capture by write
      dump1(0, 1'b1, 1'b0);
      dump1(2, 1'b0, 1'b1);
      snap_check("R5 first dumps", 16'h0105, 16'h0400);

      // R6: protected dump is lost, early/ovfl untouched; R4 capture on irq_out edge
      dump1(0, 1'b0, 1'b1);
      step(); irq_out = 1'b1; step(); irq_out = 1'b0;
      rd(8'h82, v); chk("R6 word A after lost dump", v, 16'h0105);
      rd(8'h83, v); chk("R6 word B lost dump flag", v, 16'h0401);

      // R7: prompt read releases ch0; R4 capture on irq_in edge
      rd(8'h90, v);
      step(); irq_in = 1'b1; step(); irq_in = 1'b0;
      rd(8'h82, v); chk("R7 release after read", v, 16'h0104);

      // R7: dump between capture and prompt read keeps protection
      dump1(2, 1'b1, 1'b0);
      rd(8'h92, v);
      snap_check("R7 protected through read", 16'h0104, 16'h0405);
      rd(8'h92, v);
      snap_check("R7 release on later read", 16'h0100, 16'h0405);

      // R7: first dump after capture, then prompt read, is still reported
      dump1(3, 1'b0, 1'b0);
      rd(8'h93, v);
      snap_check("R7 unseen dump kept", 16'h0108, 16'h0405);

      // R11: clear waits for the strobe to fall; capture while held still shows the flag
      step(); bus_rd = 1'b1; bus_addr = 8'h93;
      step(); irq_out = 1'b1;
      step(); irq_out = 1'b0;
      step(); bus_rd = 1'b0;
      rd(8'h82, v); chk("R11 flag held during read", v, 16'h0108);
      snap_check("R11 flag cleared after strobe", 16'h0100, 16'h0405);

      // R8: per-channel clear writes
      wr(8'h88);
      snap_check("R8 ch0 clear", 16'h0100, 16'h0404);
      wr(8'h8A);
      snap_check("R8 ch2 clear", 16'h0100, 16'h0000);
      step(); bus_wr = 1'b1; bus_addr = 8'h8A;
      ch_dump[2] = 1'b1; ch_dump_early[2] = 1'b1; ch_dump_ovfl[2] = 1'b1;
      step(); bus_wr = 1'b0; ch_dump = '0; ch_dump_early = '0; ch_dump_ovfl = '0;
      snap_check("R8 dump wins over clear", 16'h0504, 16'h0400);

      // R9: disabled channel cleared, early kept, dump ignored
      step(); ch_clk_en[2] = 1'b0; ch_clk_en[4] = 1'b0; ch_dump[4] = 1'b1; ch_dump_early[4] = 1'b1;
      step(); ch_clk_en = '1; ch_dump = '0; ch_dump_early = '0;
      snap_check("R9 clock enable low", 16'h0500, 16'h0000);

      // R10: statistics flag
      step(); stat_new = 1'b1; step(); stat_new = 1'b0;
      snap_check("R10 stat set", 16'h8500, 16'h0000);
      rd(8'h98, v);
      snap_check("R10 stat cleared by read", 16'h0500, 16'h0000);
      step(); stat_new = 1'b1; step(); stat_new = 1'b0;
      rd(8'h98, v);
      snap_check("R10 read ignored when unseen", 16'h8500, 16'h0000);
      wr(8'h8F);
      snap_check("R10 all-clear write", 16'h0500, 16'h0000);
      step(); stat_new = 1'b1; bus_wr = 1'b1; bus_addr = 8'h8F;
      step(); stat_new = 1'b0; bus_wr = 1'b0;
      snap_check("R10 set wins over clear", 16'h8500, 16'h0000);

      // R2: other address reads zero; R4: no capture without an event
      rd(8'h84, v); chk("R2 unmapped read", v, 16'h0000);
      dump1(5, 1'b1, 1'b0);
      rd(8'h82, v); chk("R4 hold without event", v, 16'h8500);
      snap_check("R4 capture after dump", 16'hA520, 16'h0000);

      // R1: software reset
      step(); sw_reset = 1'b1; step(); sw_reset = 1'b0;
      rd(8'h82, v); chk("R1 sw reset word A", v, 16'h0000);
      rd(8'h83, v); chk("R1 sw reset word B", v, 16'h0000);
      snap_check("R1 live flags cleared", 16'h0000, 16'h0000);

      repeat (3) step();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule